// File: doc/BRIEF.md
# USB Device Control and Event Interrupt Register

This block holds the top-level control word of a full-speed USB device controller. A processor writes it to turn the bus transceiver on, to send a wake-up request out of suspend, and to mask interrupt sources. It reads the word back to see which bus events the device engine has reported.

The device engine drives three event inputs: host bus reset, suspend seen and resume seen. It also drives a level that shows the controller is active. Each event sets a sticky flag. Software clears a flag by writing a 1 to its bit. One registered interrupt line combines the flags that are enabled.

The single 32-bit word holds four kinds of access. Enable and mask bits are read/write. Event flags are write-1-to-clear. The wake-up command is write-1-to-set and clears itself. The activity indicator is read-only.

Top module: `usbd_ctl_irq_reg`

## Requirements
- R1: After a synchronous reset the word reads 0x000000A0. Both mask bits (5 and 7) are 1, every other bit is 0, and `irq_o`, `xcvr_en_o` and `force_resume_o` are 0.
- R2: Bit 0 is read/write and is the transceiver enable. `xcvr_en_o` equals the stored bit and changes on the clock edge that captures the write.
- R3: Bit 1 reads the `active_i` level sampled one clock earlier. Writes to bit 1 have no effect.
- R4: Writing 1 to bit 2 makes `force_resume_o` high for exactly the one cycle after the write edge. Bit 2 always reads 0. Writing 0 to bit 2 produces no pulse.
- R5: A high cycle on `evt_resume_i`, `evt_suspend_i` or `evt_reset_i` sets flag bit 3, bit 4 or bit 6 respectively. The flag stays set until software clears it.
- R6: Writing 1 to a flag bit (3, 4 or 6) clears only that flag. Writing 0 to a flag bit leaves it unchanged.
- R7: Bit 5 (suspend/resume mask) and bit 7 (host-reset mask) are read/write. A value of 1 means the source is disabled.
- R8: `irq_o` = (bit6 AND NOT bit7) OR ((bit3 OR bit4) AND NOT bit5). It is registered and always agrees with the flag and mask values read in the same cycle.
- R9: If an event and a write-1-to-clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Bits 31:8 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Current register value |
| evt_reset_i | input | 1 | Host bus reset detected |
| evt_suspend_i | input | 1 | Suspend detected |
| evt_resume_i | input | 1 | Resume detected |
| active_i | input | 1 | Controller activity level |
| xcvr_en_o | output | 1 | Transceiver pin enable |
| force_resume_o | output | 1 | One-cycle wake-up request |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A stuck or lost event flag shows up on `rd_data_o` in the cycle after the event. If the interrupt register and the flags disagree, `irq_o` differs from the read value in that same cycle. A wake-up command that stays set would show as a second `force_resume_o` cycle, or as bit 2 reading back as 1, one cycle after the write. A mask or enable bit that is stored wrong is visible on the read port and on `xcvr_en_o` right after the capturing edge.

// File: rtl/usbd_ctl_pkg.sv
package usbd_ctl_pkg;
  localparam int BIT_EN     = 0;
  localparam int BIT_ACT    = 1;
  localparam int BIT_WAKE   = 2;
  localparam int BIT_RESF   = 3;
  localparam int BIT_SUSF   = 4;
  localparam int BIT_SRMSK  = 5;
  localparam int BIT_RSTF   = 6;
  localparam int BIT_RSTMSK = 7;
  localparam int USED_W     = 8;
  localparam int NUM_EVT    = 3;

  typedef enum logic [1:0] {
    EVT_RESUME  = 2'd0,
    EVT_SUSPEND = 2'd1,
    EVT_HRESET  = 2'd2
  } evt_idx_e;

  function automatic int evt_bit(input int idx);
    case (idx)
      0:       return BIT_RESF;
      1:       return BIT_SUSF;
      default: return BIT_RSTF;
    endcase
  endfunction
endpackage

// File: rtl/usbd_evt_flag.sv
module usbd_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_d_o,
  output logic flag_q_o
);
  // a set in the same cycle as a clear wins
  assign flag_d_o = set_i | (flag_q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) flag_q_o <= 1'b0;
    else     flag_q_o <= flag_d_o;
  end
endmodule

// File: rtl/usbd_irq_combine.sv
module usbd_irq_combine (
  input  logic hreset_flag_i,
  input  logic hreset_mask_i,
  input  logic suspend_flag_i,
  input  logic resume_flag_i,
  input  logic susres_mask_i,
  output logic irq_d_o
);
  logic hreset_req;
  logic susres_req;

  always_comb begin
    hreset_req = hreset_flag_i & ~hreset_mask_i;
    susres_req = (suspend_flag_i | resume_flag_i) & ~susres_mask_i;
    irq_d_o    = hreset_req | susres_req;
  end
endmodule

// File: rtl/usbd_ctl_irq_reg.sv
module usbd_ctl_irq_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              evt_reset_i,
  input  logic              evt_suspend_i,
  input  logic              evt_resume_i,
  input  logic              active_i,
  output logic              xcvr_en_o,
  output logic              force_resume_o,
  output logic              irq_o
);
  import usbd_ctl_pkg::*;

  localparam int RSVD_W = DATA_W - USED_W;

  logic [NUM_EVT-1:0] evt_in;
  logic [NUM_EVT-1:0] flag_d;
  logic [NUM_EVT-1:0] flag_q;
  logic               en_q;
  logic               active_q;
  logic               srmsk_q;
  logic               rstmsk_q;
  logic               srmsk_d;
  logic               rstmsk_d;
  logic               wake_q;
  logic               irq_d;

  assign evt_in[EVT_RESUME]  = evt_resume_i;
  assign evt_in[EVT_SUSPEND] = evt_suspend_i;
  assign evt_in[EVT_HRESET]  = evt_reset_i;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    localparam int POS = evt_bit(g);
    usbd_evt_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .set_i    (evt_in[g]),
      .clr_i    (wr_en_i & wr_data_i[POS]),
      .flag_d_o (flag_d[g]),
      .flag_q_o (flag_q[g])
    );
  end

  assign srmsk_d  = wr_en_i ? wr_data_i[BIT_SRMSK]  : srmsk_q;
  assign rstmsk_d = wr_en_i ? wr_data_i[BIT_RSTMSK] : rstmsk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      srmsk_q  <= 1'b1;
      rstmsk_q <= 1'b1;
      active_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (wr_en_i) en_q <= wr_data_i[BIT_EN];
      srmsk_q  <= srmsk_d;
      rstmsk_q <= rstmsk_d;
      active_q <= active_i;
      wake_q   <= wr_en_i & wr_data_i[BIT_WAKE];
    end
  end

  // interrupt is computed from next-state values so it lines up with the flags
  usbd_irq_combine u_irq (
    .hreset_flag_i  (flag_d[EVT_HRESET]),
    .hreset_mask_i  (rstmsk_d),
    .suspend_flag_i (flag_d[EVT_SUSPEND]),
    .resume_flag_i  (flag_d[EVT_RESUME]),
    .susres_mask_i  (srmsk_d),
    .irq_d_o        (irq_d)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= irq_d;
  end

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[BIT_EN]     = en_q;
    rd_data_o[BIT_ACT]    = active_q;
    rd_data_o[BIT_WAKE]   = 1'b0;
    rd_data_o[BIT_RESF]   = flag_q[EVT_RESUME];
    rd_data_o[BIT_SUSF]   = flag_q[EVT_SUSPEND];
    rd_data_o[BIT_SRMSK]  = srmsk_q;
    rd_data_o[BIT_RSTF]   = flag_q[EVT_HRESET];
    rd_data_o[BIT_RSTMSK] = rstmsk_q;
    if (RSVD_W > 0) rd_data_o[DATA_W-1:USED_W] = '0;
  end

  assign xcvr_en_o      = en_q;
  assign force_resume_o = wake_q;
endmodule

// File: rtl/usbd_ctl_irq_reg_chk.sv
module usbd_ctl_irq_reg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              evt_reset_i,
  input logic              evt_suspend_i,
  input logic              evt_resume_i,
  input logic              xcvr_en_o,
  input logic              force_resume_o,
  input logic              irq_o
);
  assert_xcvr_follows_R2: assert property (@(posedge clk) disable iff (rst)
    xcvr_en_o == rd_data_o[0]);

  assert_wake_from_write_R4: assert property (@(posedge clk) disable iff (rst)
    force_resume_o |-> $past(wr_en_i && wr_data_i[2]));

  assert_wake_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[2] == 1'b0);

  assert_reset_evt_wins_R9: assert property (@(posedge clk) disable iff (rst)
    evt_reset_i |=> rd_data_o[6]);

  assert_suspend_evt_sets_R5: assert property (@(posedge clk) disable iff (rst)
    evt_suspend_i |=> rd_data_o[4]);

  assert_resume_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o[3] && !(wr_en_i && wr_data_i[3])) |=> rd_data_o[3]);

  assert_irq_matches_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((rd_data_o[6] && !rd_data_o[7]) ||
              ((rd_data_o[3] || rd_data_o[4]) && !rd_data_o[5])));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[DATA_W-1:8] == '0);
endmodule

bind usbd_ctl_irq_reg usbd_ctl_irq_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .rd_data_o      (rd_data_o),
  .evt_reset_i    (evt_reset_i),
  .evt_suspend_i  (evt_suspend_i),
  .evt_resume_i   (evt_resume_i),
  .xcvr_en_o      (xcvr_en_o),
  .force_resume_o (force_resume_o),
  .irq_o          (irq_o)
);

// File: tb/usbd_ctl_irq_reg_tb_top.sv
module usbd_ctl_irq_reg_tb_top;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              evt_reset_i = 1'b0;
  logic              evt_suspend_i = 1'b0;
  logic              evt_resume_i = 1'b0;
  logic              active_i = 1'b0;
  logic              xcvr_en_o;
  logic              force_resume_o;
  logic              irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  usbd_ctl_irq_reg #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .evt_reset_i(evt_reset_i),
    .evt_suspend_i(evt_suspend_i), .evt_resume_i(evt_resume_i),
    .active_i(active_i), .xcvr_en_o(xcvr_en_o),
    .force_resume_o(force_resume_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 word", rd_data_o, 32'h000000A0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 xcvr", {31'd0, xcvr_en_o}, 0);
    chk("R1 wake", {31'd0, force_resume_o}, 0);
  endtask

  task automatic t_enable();
    wr(32'hA1);
    chk("R2 set", {31'd0, xcvr_en_o}, 1);
    chk("R2 read", rd_data_o, 32'hA1);
    wr(32'hA0);
    chk("R2 clear", {31'd0, xcvr_en_o}, 0);
  endtask

  task automatic t_active();
    wr(32'hA2);
    chk("R3 write ignored", {31'd0, rd_data_o[1]}, 0);
    active_i = 1'b1;
    @(negedge clk);
    chk("R3 reflects", {31'd0, rd_data_o[1]}, 1);
    wr(32'hA0);
    chk("R3 write0 ignored", {31'd0, rd_data_o[1]}, 1);
    active_i = 1'b0;
    @(negedge clk);
    chk("R3 falls", {31'd0, rd_data_o[1]}, 0);
  endtask

  task automatic t_wake();
    wr(32'hA4);
    chk("R4 pulse", {31'd0, force_resume_o}, 1);
    chk("R4 reads0", {31'd0, rd_data_o[2]}, 0);
    @(negedge clk);
    chk("R4 one cycle", {31'd0, force_resume_o}, 0);
    wr(32'hA0);
    chk("R4 write0 no pulse", {31'd0, force_resume_o}, 0);
  endtask

  task automatic t_events();
    evt_suspend_i = 1'b1; @(negedge clk); evt_suspend_i = 1'b0;
    chk("R5 suspend flag", rd_data_o, 32'hB0);
    chk("R8 masked", {31'd0, irq_o}, 0);
    evt_resume_i = 1'b1; @(negedge clk); evt_resume_i = 1'b0;
    @(negedge clk);
    chk("R5 resume flag held", rd_data_o, 32'hB8);
    wr(32'h80);
    chk("R7 srmask cleared", rd_data_o, 32'h98);
    chk("R8 susres irq", {31'd0, irq_o}, 1);
    wr(32'h90);
    chk("R6 clear only suspend", rd_data_o, 32'h88);
    chk("R8 resume keeps irq", {31'd0, irq_o}, 1);
    wr(32'h88);
    chk("R6 clear resume", rd_data_o, 32'h80);
    chk("R8 irq drops", {31'd0, irq_o}, 0);
  endtask

  task automatic t_hreset();
    evt_reset_i = 1'b1; @(negedge clk); evt_reset_i = 1'b0;
    chk("R5 reset flag", rd_data_o, 32'hC0);
    chk("R8 reset masked", {31'd0, irq_o}, 0);
    wr(32'h20);
    chk("R7 masks rw", rd_data_o, 32'h60);
    chk("R8 reset irq", {31'd0, irq_o}, 1);
    // clear and event in the same cycle
    wr_en_i = 1'b1; wr_data_i = 32'h60; evt_reset_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0; evt_reset_i = 1'b0;
    chk("R9 event wins", rd_data_o, 32'h60);
    chk("R9 irq stays", {31'd0, irq_o}, 1);
    wr(32'h60);
    chk("R6 reset cleared", rd_data_o, 32'h20);
    chk("R8 irq off", {31'd0, irq_o}, 0);
  endtask

  task automatic t_reserved();
    wr(32'hFFFF_FF00 | 32'hA0);
    chk("R10 reserved", rd_data_o, 32'hA0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_active();
    t_wake();
    t_events();
    t_hreset();
    t_reserved();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule